// File: doc/BRIEF.md
# Sideband Auxiliary Request Framer

This block turns one command descriptor for the sideband auxiliary channel into the byte stream that a channel engine sends. A descriptor carries a 20-bit address, a 4-bit request code, a payload length and up to sixteen payload bytes. The block sends a four-byte header on a valid/ready byte stream. For a write, the payload bytes follow the header. The block then waits for the engine's reply and reports an outcome code, the reply nibble and a byte count as a one-cycle result pulse.

Only one request is handled at a time. A request is taken when `req_valid` is high while `busy` is low. `busy` stays high until the result pulse appears. A descriptor that is oversized, or that carries a code the block does not handle, is answered on the next cycle and emits no bytes. The caller's delay value is divided by ten and passed to the engine on `eng_delay`.

Result codes on `done_code`: 0 success, 1 timeout, 2 nonzero flags, 3 channel error, 4 payload too large, 5 invalid request.

Top module: `aux_req_framer`

## Requirements
- R1: A taken request with `req_len` above 16 emits no byte and gives `done_valid` with `done_code`=4, count 0 and reply 0 on the cycle after it is taken.
- R2: Header byte 0 is address bits 7:0 and header byte 1 is address bits 15:8.
- R3: Header byte 2 carries the request code in bits 7:4 and address bits 19:16 in bits 3:0.
- R4: Header byte 3 bits 3:0 hold the length minus one, or 0 when the length is 0.
- R5: Header byte 3 bits 7:4 hold 3 when the length is 0. Otherwise they hold the low four bits of the total transmit size, which is 4 plus the length for writes and 4 for reads (so a 16-byte write gives 4, and a 12-byte write gives 0).
- R6: A write (code bit 0 = 0) sends the header and then payload byte k taken from `req_data[8k+7:8k]`. A read (code bit 0 = 1) sends only the header. `tx_last` marks the final byte, and `tx_data` holds steady while `tx_ready` is low.
- R7: A reply status of 1, 2 or 3 ends the request with `done_code` equal to that status, count 0 and reply 0.
- R8: A reply status of 0 gives `done_code`=0 and reply = `rpl_ack[7:4]`. The count is the requested length for a write. For a read it is the smaller of `rpl_len` and the requested length.
- R9: While busy, `eng_delay` equals the taken `req_delay` divided by 10, rounded down.
- R10: `busy` rises on the cycle after a request is taken and falls together with the result pulse. `req_valid` has no effect while busy, and each request gives exactly one result pulse.
- R11: With bit 2 (the continuation bit) ignored, only codes 0, 1, 8 and 9 are handled. Any other code emits no byte and gives `done_code`=5 on the next cycle. R1 is checked before R11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Descriptor present; taken when busy is low |
| req_addr | input | 20 | Target address |
| req_code | input | 4 | Request code |
| req_len | input | 5 | Payload length in bytes |
| req_data | input | 128 | Payload, byte k in bits 8k+7:8k |
| req_delay | input | 8 | Caller delay value |
| busy | output | 1 | A request is in flight |
| tx_valid | output | 1 | Byte stream valid |
| tx_ready | input | 1 | Byte stream ready |
| tx_data | output | 8 | Byte stream data |
| tx_last | output | 1 | Final byte of the frame |
| eng_delay | output | 8 | Delay divided by 10 for the engine |
| rpl_valid | input | 1 | Engine reply present (used while waiting) |
| rpl_status | input | 2 | Reply status |
| rpl_ack | input | 8 | Acknowledge byte |
| rpl_len | input | 5 | Bytes received by the engine |
| done_valid | output | 1 | One-cycle result pulse |
| done_code | output | 3 | Outcome code |
| done_count | output | 5 | Byte count result |
| done_reply | output | 4 | Reply nibble |

## Verification
The hardest condition to reach from the ports is a second descriptor arriving while a frame is already outstanding. The stimulus shows that it is ignored by raising `req_valid` with an oversized length during the reply wait of every run. An accepted oversize request would add an extra result pulse, so the bench checks for a single pulse with the first request's values. The nibble truncation at 12 and 16 payload bytes is driven through the vector table. Stream back-pressure is exercised by holding `tx_ready` low in the middle of a header.

// File: rtl/aux_req_framer.sv
module aux_req_framer #(
  parameter int DELAY_DIV = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_valid,
  input  logic [19:0]  req_addr,
  input  logic [3:0]   req_code,
  input  logic [4:0]   req_len,
  input  logic [127:0] req_data,
  input  logic [7:0]   req_delay,
  output logic         busy,
  output logic         tx_valid,
  input  logic         tx_ready,
  output logic [7:0]   tx_data,
  output logic         tx_last,
  output logic [7:0]   eng_delay,
  input  logic         rpl_valid,
  input  logic [1:0]   rpl_status,
  input  logic [7:0]   rpl_ack,
  input  logic [4:0]   rpl_len,
  output logic         done_valid,
  output logic [2:0]   done_code,
  output logic [4:0]   done_count,
  output logic [3:0]   done_reply
);

  localparam logic [2:0] RES_OK  = 3'd0;
  localparam logic [2:0] RES_BIG = 3'd4;
  localparam logic [2:0] RES_BAD = 3'd5;
  localparam logic [4:0] MAX_LEN = 5'd16;

  typedef enum logic [1:0] {ST_IDLE, ST_TX, ST_WAIT} st_t;
  st_t st;

  logic [4:0]   idx;
  logic [19:0]  r_addr;
  logic [3:0]   r_code;
  logic [4:0]   r_len;
  logic [127:0] r_data;

  logic [3:0] in_mask;
  logic       in_big, in_bad, accept;
  assign in_mask = req_code & 4'b1011;
  assign in_big  = req_len > MAX_LEN;
  assign in_bad  = !(in_mask == 4'h0 || in_mask == 4'h1 ||
                     in_mask == 4'h8 || in_mask == 4'h9);
  assign accept  = req_valid && (st == ST_IDLE);

  logic       is_wr;
  logic [4:0] tot, last_idx;
  logic [3:0] lenm1, size_nib, pidx;
  assign is_wr    = ~r_code[0];
  assign tot      = is_wr ? (5'd4 + r_len) : 5'd4;
  assign last_idx = tot - 5'd1;
  assign lenm1    = (r_len == 5'd0) ? 4'd0 : 4'(r_len - 5'd1);
  assign size_nib = (r_len == 5'd0) ? 4'd3 : tot[3:0];
  assign pidx     = 4'(idx - 5'd4);

  always_comb begin
    case (idx)
      5'd0:    tx_data = r_addr[7:0];
      5'd1:    tx_data = r_addr[15:8];
      5'd2:    tx_data = {r_code, r_addr[19:16]};
      5'd3:    tx_data = {size_nib, lenm1};
      default: tx_data = r_data[{pidx, 3'b000} +: 8];
    endcase
  end

  assign busy     = (st != ST_IDLE);
  assign tx_valid = (st == ST_TX);
  assign tx_last  = tx_valid && (idx == last_idx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      idx        <= '0;
      r_addr     <= '0;
      r_code     <= '0;
      r_len      <= '0;
      r_data     <= '0;
      eng_delay  <= '0;
      done_valid <= 1'b0;
      done_code  <= RES_OK;
      done_count <= '0;
      done_reply <= '0;
    end else begin
      done_valid <= 1'b0;
      case (st)
        ST_IDLE: if (accept) begin
          if (in_big || in_bad) begin
            done_valid <= 1'b1;
            done_code  <= in_big ? RES_BIG : RES_BAD;
            done_count <= '0;
            done_reply <= '0;
          end else begin
            r_addr    <= req_addr;
            r_code    <= req_code;
            r_len     <= req_len;
            r_data    <= req_data;
            eng_delay <= 8'(req_delay / 8'(DELAY_DIV));
            idx       <= '0;
            st        <= ST_TX;
          end
        end
        ST_TX: if (tx_ready) begin
          if (idx == last_idx) st <= ST_WAIT;
          else idx <= idx + 5'd1;
        end
        ST_WAIT: if (rpl_valid) begin
          st         <= ST_IDLE;
          done_valid <= 1'b1;
          if (rpl_status == 2'd0) begin
            done_code  <= RES_OK;
            done_reply <= rpl_ack[7:4];
            done_count <= is_wr ? r_len : ((rpl_len < r_len) ? rpl_len : r_len);
          end else begin
            done_code  <= {1'b0, rpl_status};
            done_reply <= '0;
            done_count <= '0;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  p_big_reject_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && req_len > 5'd16) |=>
      (done_valid && done_code == 3'd4 && !tx_valid && !busy));

  p_bad_reject_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && req_len <= 5'd16 &&
     !((req_code & 4'b1011) inside {4'h0, 4'h1, 4'h8, 4'h9})) |=>
      (done_valid && done_code == 3'd5 && !tx_valid));

  p_hold_stream_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

  p_err_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && done_code inside {3'd1, 3'd2, 3'd3}) |->
      (done_count == 5'd0 && done_reply == 4'd0));

  p_count_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && done_code == 3'd0) |-> (done_count <= 5'd16));

  p_busy_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && req_len <= 5'd16 &&
     ((req_code & 4'b1011) inside {4'h0, 4'h1, 4'h8, 4'h9})) |=> (busy && !done_valid));

  p_busy_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> !busy);

endmodule

// File: tb/aux_req_framer_tb_top.sv
module aux_req_framer_tb_top;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic         rst_n;
  logic         req_valid;
  logic [19:0]  req_addr;
  logic [3:0]   req_code;
  logic [4:0]   req_len;
  logic [127:0] req_data;
  logic [7:0]   req_delay;
  logic         busy, tx_valid, tx_ready, tx_last;
  logic [7:0]   tx_data, eng_delay;
  logic         rpl_valid;
  logic [1:0]   rpl_status;
  logic [7:0]   rpl_ack;
  logic [4:0]   rpl_len;
  logic         done_valid;
  logic [2:0]   done_code;
  logic [4:0]   done_count;
  logic [3:0]   done_reply;

  aux_req_framer dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_code(req_code), .req_len(req_len), .req_data(req_data),
    .req_delay(req_delay), .busy(busy), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last),
    .eng_delay(eng_delay), .rpl_valid(rpl_valid), .rpl_status(rpl_status),
    .rpl_ack(rpl_ack), .rpl_len(rpl_len), .done_valid(done_valid),
    .done_code(done_code), .done_count(done_count), .done_reply(done_reply)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  typedef struct packed {
    logic [3:0]  code;
    logic [4:0]  len;
    logic [19:0] addr;
    logic [7:0]  dly;
    logic [1:0]  st;
    logic [7:0]  ack;
    logic [4:0]  rx;
    logic [2:0]  res;
    logic [4:0]  cnt;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [0:NV-1] = '{
    '{4'h8, 5'd4,  20'hABCDE, 8'd25,  2'd0, 8'h00, 5'd0,  3'd0, 5'd4},
    '{4'h9, 5'd16, 20'h12345, 8'd99,  2'd0, 8'h20, 5'd20, 3'd0, 5'd16},
    '{4'h5, 5'd3,  20'h0F00F, 8'd10,  2'd0, 8'h10, 5'd2,  3'd0, 5'd2},
    '{4'h4, 5'd0,  20'h00050, 8'd0,   2'd0, 8'h00, 5'd0,  3'd0, 5'd0},
    '{4'h8, 5'd16, 20'hFFFFF, 8'd255, 2'd1, 8'hF0, 5'd0,  3'd1, 5'd0},
    '{4'h9, 5'd0,  20'h80001, 8'd9,   2'd2, 8'h30, 5'd1,  3'd2, 5'd0},
    '{4'h0, 5'd12, 20'h3A5C7, 8'd47,  2'd3, 8'h50, 5'd0,  3'd3, 5'd0},
    '{4'h9, 5'd8,  20'h76543, 8'd120, 2'd0, 8'hF0, 5'd8,  3'd0, 5'd8}
  };

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pay(int k);
    return 8'(8'hC3 + k * 37);
  endfunction

  function automatic logic [7:0] expb(logic [3:0] code, logic [4:0] len,
                                      logic [19:0] addr, int i);
    logic [3:0] nib;
    logic [3:0] lm1;
    lm1 = (len == 0) ? 4'd0 : 4'(len - 5'd1);
    if (len == 0) nib = 4'd3;
    else if (!code[0]) nib = 4'(5'd4 + len);
    else nib = 4'd4;
    case (i)
      0: return addr[7:0];
      1: return addr[15:8];
      2: return {code, addr[19:16]};
      3: return {nib, lm1};
      default: return pay(i - 4);
    endcase
  endfunction

  task automatic drive_req(logic [3:0] code, logic [4:0] len,
                           logic [19:0] addr, logic [7:0] dly);
    req_valid = 1'b1;
    req_code  = code;
    req_len   = len;
    req_addr  = addr;
    req_delay = dly;
    for (int k = 0; k < 16; k++) req_data[k*8 +: 8] = pay(k);
  endtask

  task automatic run_frame(vec_t v, bit stall);
    int n;
    @(negedge clk);
    drive_req(v.code, v.len, v.addr, v.dly);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R10 busy after take", int'(busy), 1);
    chk("R9 engine delay", int'(eng_delay), int'(v.dly) / 10);
    n = v.code[0] ? 4 : 4 + int'(v.len);
    for (int i = 0; i < n; i++) begin
      if (stall && i == 1) begin
        tx_ready = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R6 held valid", int'(tx_valid), 1);
        chk("R6 held byte", int'(tx_data), int'(expb(v.code, v.len, v.addr, 1)));
        tx_ready = 1'b1;
      end
      chk("R6 stream valid", int'(tx_valid), 1);
      if (i < 2)       chk("R2 address byte", int'(tx_data), int'(expb(v.code, v.len, v.addr, i)));
      else if (i == 2) chk("R3 code byte", int'(tx_data), int'(expb(v.code, v.len, v.addr, i)));
      else if (i == 3) begin
        chk("R4 length nibble", int'(tx_data[3:0]), int'(expb(v.code, v.len, v.addr, i) & 8'h0F));
        chk("R5 size nibble", int'(tx_data[7:4]), int'(expb(v.code, v.len, v.addr, i) >> 4));
      end else         chk("R6 payload byte", int'(tx_data), int'(expb(v.code, v.len, v.addr, i)));
      chk("R6 last flag", int'(tx_last), int'(i == n - 1));
      @(negedge clk);
    end
    chk("R6 stream ends", int'(tx_valid), 0);
    drive_req(4'h8, 5'd17, 20'h11111, 8'd0);
    rpl_valid  = 1'b1;
    rpl_status = v.st;
    rpl_ack    = v.ack;
    rpl_len    = v.rx;
    @(negedge clk);
    rpl_valid = 1'b0;
    req_valid = 1'b0;
    chk("R10 result pulse", int'(done_valid), 1);
    chk(v.st == 0 ? "R8 result code" : "R7 result code", int'(done_code), int'(v.res));
    chk(v.st == 0 ? "R8 count" : "R7 count", int'(done_count), int'(v.cnt));
    chk(v.st == 0 ? "R8 reply" : "R7 reply", int'(done_reply), v.st == 0 ? int'(v.ack >> 4) : 0);
    chk("R10 busy released", int'(busy), 0);
    @(negedge clk);
    chk("R10 ignored while busy", int'(done_valid), 0);
  endtask

  task automatic run_reject(logic [3:0] code, logic [4:0] len, int exp_res, string tag);
    @(negedge clk);
    drive_req(code, len, 20'h2468A, 8'd50);
    @(negedge clk);
    req_valid = 1'b0;
    chk(tag, int'(done_valid), 1);
    chk(tag, int'(done_code), exp_res);
    chk(tag, int'(tx_valid), 0);
    chk(tag, int'(busy), 0);
    @(negedge clk);
    chk(tag, int'(tx_valid), 0);
    chk(tag, int'(done_valid), 0);
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0; req_addr = '0; req_code = '0; req_len = '0;
    req_data = '0; req_delay = '0; tx_ready = 1'b1;
    rpl_valid = 1'b0; rpl_status = '0; rpl_ack = '0; rpl_len = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 reset busy", int'(busy), 0);
    chk("R6 reset stream", int'(tx_valid), 0);
    chk("R10 reset pulse", int'(done_valid), 0);

    for (int i = 0; i < NV; i++) run_frame(VECS[i], 1'b0);

    run_frame('{4'h8, 5'd2, 20'h9ABCD, 8'd31, 2'd0, 8'h00, 5'd0, 3'd0, 5'd2}, 1'b1);
    run_reject(4'h8, 5'd17, 4, "R1 size 17");
    run_reject(4'h9, 5'd31, 4, "R1 size 31");
    run_reject(4'h2, 5'd1,  5, "R11 code 2");
    run_reject(4'hA, 5'd4,  5, "R11 code A");
    run_reject(4'h3, 5'd0,  5, "R11 code 3");
    run_reject(4'h2, 5'd20, 4, "R1 before R11");
    run_frame('{4'hD, 5'd5, 20'h0ABC1, 8'd9, 2'd0, 8'h80, 5'd3, 3'd0, 5'd3}, 1'b0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule